// File: doc/BRIEF.md
# Constant Off-Time Current Chopper for One H-Bridge

This block regulates the winding current of one phase of a bipolar stepper motor. It drives the four gates of an H-bridge, an upper and a lower switch on each of two legs. The current-sense comparator arrives as a digital flag. The phase sequencer supplies a direction bit and a phase-enable bit. The block turns the bridge on in the requested polarity. When the current crosses the reference, it turns the bridge off for a fixed off-time and then turns it back on.

During the off-time the winding recirculates in one of two decay styles. Fast decay reverses the voltage across the winding and rectifies only through a lower switch, so the current can never build in the reverse direction. Slow decay shorts the winding through the two upper switches. Every change of switch state inside a leg is separated by a dead-time gap. All interval lengths are parameters counted in clock cycles: dead time `DEAD`, blanking `BLANK`, minimum on-time `MIN_ON`, and off-time `OFF_T`, which must be greater than `DEAD`.

The gate outputs are registered. Every decision made at a clock edge appears on the pins in the cycle that follows that edge. The gate vector is written {hs_a, ls_a, hs_b, ls_b} below.

Top module: `chopper_ctrl`

## Requirements
- R1: While `rst` is high, or while `enable` or `phase_on` is sampled low, all four gates are low from the cycle after that edge onward.
- R2: When the bridge becomes active from the disabled state, all gates stay low for `DEAD` cycles. The conducting pattern then follows. With `phase_dir`=1 it is 1001 (hs_a and ls_b). With `phase_dir`=0 it is 0110 (hs_b and ls_a).
- R3: A high `over_ref` in the first `BLANK` cycles of an on-time has no effect. If no later assertion follows, the conducting pattern stays.
- R4: An on-time lasts at least `MIN_ON` cycles. A qualified `over_ref` pulse seen before then is remembered and ends the on-time after exactly `MIN_ON` cycles.
- R5: If `over_ref` is first seen high in on-cycle i (counting from 0, with i >= `BLANK`), the on-time lasts max(`MIN_ON`, i+1) cycles.
- R6: Fast decay (`slow_decay`=0) behaves as follows. All gates are low for `DEAD` cycles. After that, only the lower switch of the leg that was driven high is on: 0100 for direction 1 and 0001 for direction 0.
- R7: Slow decay (`slow_decay`=1) behaves as follows. For `DEAD` cycles only the upper switch of the leg that was driven high stays on: 1000 for direction 1 and 0010 for direction 0. After that, both upper switches are on (1010).
- R8: The interval from the end of the on-time through the end of recirculation lasts `OFF_T` cycles. A further `DEAD` cycles then follow before the conducting pattern returns. During those cycles all gates are low in fast decay. In slow decay only the upper switch of the driven leg is on.
- R9: The decay mode is sampled at the edge that ends the on-time. Any change of `slow_decay` during that off-time has no effect on it.
- R10: A change of `phase_dir` while the bridge is active forces all gates low for `DEAD` cycles. The conducting pattern of the new direction then follows.
- R11: The upper and lower gates of the same leg are never high in the same cycle. A lower gate never rises in the cycle right after its upper gate was high, and the reverse holds as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Global bridge enable; low forces all gates off |
| phase_on | input | 1 | Phase energise bit from the sequencer; low forces all gates off |
| phase_dir | input | 1 | Current polarity: 1 drives leg A high, 0 drives leg B high |
| slow_decay | input | 1 | Decay style for the next off-time: 1 slow, 0 fast |
| over_ref | input | 1 | Synchronised sense-comparator flag, high when current exceeds the reference |
| hs_a | output | 1 | Upper gate, leg A |
| ls_a | output | 1 | Lower gate, leg A |
| hs_b | output | 1 | Upper gate, leg B |
| ls_b | output | 1 | Lower gate, leg B |

## Verification
The properties assume that `over_ref`, `phase_dir` and `slow_decay` are already synchronous to `clk`. They treat any inputs as legal, but the minimum-on property only claims continuity while the bridge stays enabled and the direction matches the pattern on the pins. The stimulus changes every input half a cycle away from the active edge. It holds the direction and mode steady except in the directed tests that deliberately move them mid-cycle. It pulses `over_ref` only at on-cycle indices chosen to land inside blanking, between blanking and the minimum on-time, or past both.

// File: rtl/chop_pkg.sv
package chop_pkg;

  // One-hot controller state
  typedef enum logic [4:0] {
    ST_OFF    = 5'b00001,  // bridge disabled, all gates low
    ST_ON     = 5'b00010,  // conducting in the latched polarity
    ST_DOFF   = 5'b00100,  // dead gap after the on-time
    ST_RECIRC = 5'b01000,  // decay with synchronous rectification
    ST_DON    = 5'b10000   // dead gap before conduction
  } chop_state_e;

  typedef struct packed {
    logic hs_a;
    logic ls_a;
    logic hs_b;
    logic ls_b;
  } gate_t;

  localparam gate_t GATES_OFF = '{hs_a: 1'b0, ls_a: 1'b0, hs_b: 1'b0, ls_b: 1'b0};

endpackage

// File: rtl/chop_timer.sv
// Cycles spent in the current state; cleared on every state entry and saturating.
module chop_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  output logic [CNT_W-1:0] elapsed
);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      elapsed <= '0;
    end else if (elapsed != {CNT_W{1'b1}}) begin
      elapsed <= elapsed + 1'b1;
    end
  end

endmodule

// File: rtl/chop_trip_qual.sv
// Qualifies the comparator flag: blanked at the start of each on-time,
// remembered once seen, released no earlier than the minimum on-time.
module chop_trip_qual #(
  parameter int CNT_W  = 8,
  parameter int BLANK  = 4,
  parameter int MIN_ON = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_on,
  input  logic             restart,
  input  logic             over_ref,
  input  logic [CNT_W-1:0] elapsed,
  output logic             trip_go
);

  localparam logic [CNT_W-1:0] BLANK_C   = CNT_W'(BLANK);
  localparam logic [CNT_W-1:0] MINON_END = CNT_W'(MIN_ON - 1);

  logic seen_q;
  logic past_blank;
  logic hit_now;

  assign past_blank = (elapsed >= BLANK_C);
  assign hit_now    = in_on && over_ref && past_blank;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      seen_q <= 1'b0;
    end else if (hit_now) begin
      seen_q <= 1'b1;
    end
  end

  assign trip_go = in_on && (seen_q || hit_now) && (elapsed >= MINON_END);

endmodule

// File: rtl/chop_seq.sv
// Controller sequencing: on-time, dead gaps, recirculation, disable and polarity change.
module chop_seq
  import chop_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DEAD  = 4,
  parameter int OFF_T = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             dir_in,
  input  logic             slow_in,
  input  logic             trip_go,
  input  logic [CNT_W-1:0] elapsed,
  output chop_state_e      state_q,
  output chop_state_e      state_n,
  output logic             dir_n,
  output logic             mode_n,
  output logic             hold_n,
  output logic             restart
);

  localparam int               RECIRC_LEN = OFF_T - DEAD;
  localparam logic [CNT_W-1:0] DEAD_END   = CNT_W'(DEAD - 1);
  localparam logic [CNT_W-1:0] REC_END    = CNT_W'(RECIRC_LEN - 1);

  logic dir_q;
  logic mode_q;
  logic hold_q;
  logic force_restart;
  logic dir_moved;

  assign dir_moved = (dir_in != dir_q);

  always_comb begin
    state_n       = state_q;
    dir_n         = dir_q;
    mode_n        = mode_q;
    hold_n        = hold_q;
    force_restart = 1'b0;
    if (!active) begin
      state_n = ST_OFF;
      hold_n  = 1'b0;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          state_n = ST_DON;
          hold_n  = 1'b0;
          dir_n   = dir_in;
        end
        ST_DON: begin
          if (!hold_q) begin
            dir_n = dir_in;
            if (elapsed == DEAD_END) state_n = ST_ON;
          end else if (dir_moved) begin
            hold_n        = 1'b0;
            dir_n         = dir_in;
            force_restart = 1'b1;
          end else if (elapsed == DEAD_END) begin
            state_n = ST_ON;
          end
        end
        ST_ON: begin
          if (dir_moved) begin
            state_n = ST_DON;
            hold_n  = 1'b0;
            dir_n   = dir_in;
          end else if (trip_go) begin
            state_n = ST_DOFF;
            mode_n  = slow_in;
          end
        end
        ST_DOFF: begin
          if (dir_moved) begin
            state_n = ST_DON;
            hold_n  = 1'b0;
            dir_n   = dir_in;
          end else if (elapsed == DEAD_END) begin
            state_n = ST_RECIRC;
          end
        end
        ST_RECIRC: begin
          if (dir_moved) begin
            state_n = ST_DON;
            hold_n  = 1'b0;
            dir_n   = dir_in;
          end else if (elapsed == REC_END) begin
            state_n = ST_DON;
            hold_n  = mode_q;
          end
        end
        default: begin
          state_n = ST_OFF;
          hold_n  = 1'b0;
        end
      endcase
    end
  end

  assign restart = (state_n != state_q) || force_restart;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
      dir_q   <= 1'b0;
      mode_q  <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      dir_q   <= dir_n;
      mode_q  <= mode_n;
      hold_q  <= hold_n;
    end
  end

endmodule

// File: rtl/chop_gate_map.sv
// Gate pattern for a given state, polarity and decay mode.
module chop_gate_map
  import chop_pkg::*;
(
  input  chop_state_e state,
  input  logic        dir,
  input  logic        slow,
  input  logic        hold,
  output gate_t       gates
);

  always_comb begin
    gates = GATES_OFF;
    unique case (state)
      ST_ON: begin
        gates.hs_a = dir;
        gates.ls_b = dir;
        gates.hs_b = !dir;
        gates.ls_a = !dir;
      end
      ST_DOFF: begin
        if (slow) begin
          gates.hs_a = dir;
          gates.hs_b = !dir;
        end
      end
      ST_RECIRC: begin
        if (slow) begin
          gates.hs_a = 1'b1;
          gates.hs_b = 1'b1;
        end else begin
          gates.ls_a = dir;
          gates.ls_b = !dir;
        end
      end
      ST_DON: begin
        if (hold) begin
          gates.hs_a = dir;
          gates.hs_b = !dir;
        end
      end
      default: gates = GATES_OFF;
    endcase
  end

endmodule

// File: rtl/chopper_ctrl.sv
module chopper_ctrl
  import chop_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DEAD   = 4,
  parameter int BLANK  = 4,
  parameter int MIN_ON = 10,
  parameter int OFF_T  = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic phase_on,
  input  logic phase_dir,
  input  logic slow_decay,
  input  logic over_ref,
  output logic hs_a,
  output logic ls_a,
  output logic hs_b,
  output logic ls_b
);

  localparam int GATE_N = $bits(gate_t);

  chop_state_e      state_q;
  chop_state_e      state_n;
  logic             dir_n;
  logic             mode_n;
  logic             hold_n;
  logic             restart;
  logic             trip_go;
  logic [CNT_W-1:0] elapsed;
  gate_t            gates_n;
  logic [GATE_N-1:0] gate_q;

  chop_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .elapsed (elapsed)
  );

  chop_trip_qual #(.CNT_W(CNT_W), .BLANK(BLANK), .MIN_ON(MIN_ON)) u_qual (
    .clk      (clk),
    .rst      (rst),
    .in_on    (state_q == ST_ON),
    .restart  (restart),
    .over_ref (over_ref),
    .elapsed  (elapsed),
    .trip_go  (trip_go)
  );

  chop_seq #(.CNT_W(CNT_W), .DEAD(DEAD), .OFF_T(OFF_T)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .active  (enable && phase_on),
    .dir_in  (phase_dir),
    .slow_in (slow_decay),
    .trip_go (trip_go),
    .elapsed (elapsed),
    .state_q (state_q),
    .state_n (state_n),
    .dir_n   (dir_n),
    .mode_n  (mode_n),
    .hold_n  (hold_n),
    .restart (restart)
  );

  chop_gate_map u_map (
    .state (state_n),
    .dir   (dir_n),
    .slow  (mode_n),
    .hold  (hold_n),
    .gates (gates_n)
  );

  // Registered gate drivers, one flop per gate
  for (genvar g = 0; g < GATE_N; g++) begin : g_gate_reg
    always_ff @(posedge clk) begin
      if (rst) gate_q[g] <= 1'b0;
      else     gate_q[g] <= gates_n[g];
    end
  end

  assign {hs_a, ls_a, hs_b, ls_b} = gate_q;

endmodule

// File: rtl/chopper_ctrl_chk.sv
module chopper_ctrl_chk #(
  parameter int CNT_W  = 8,
  parameter int MIN_ON = 10
) (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic phase_on,
  input logic phase_dir,
  input logic hs_a,
  input logic ls_a,
  input logic hs_b,
  input logic ls_b
);

  logic [3:0]       pins;
  logic             on_pat;
  logic [CNT_W-1:0] on_cnt;

  assign pins   = {hs_a, ls_a, hs_b, ls_b};
  assign on_pat = (pins == 4'b1001) || (pins == 4'b0110);

  // Own count of consecutive conducting cycles seen on the pins
  always_ff @(posedge clk) begin
    if (rst || !on_pat)                 on_cnt <= '0;
    else if (on_cnt != {CNT_W{1'b1}})   on_cnt <= on_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst) begin
      assert_no_shoot_R11: assert (!(hs_a && ls_a) && !(hs_b && ls_b))
        else $error("same-leg overlap");
    end
  end

  assert_reset_off_R1: assert property (@(posedge clk)
    rst |=> (pins == 4'b0000));

  assert_disable_off_R1: assert property (@(posedge clk) disable iff (rst)
    (!enable || !phase_on) |=> (pins == 4'b0000));

  assert_min_on_R4: assert property (@(posedge clk) disable iff (rst)
    (on_pat && (on_cnt < CNT_W'(MIN_ON - 1)) && enable && phase_on && (phase_dir == hs_a))
      |=> on_pat);

  assert_gap_ls_a_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_a) |-> !$past(hs_a));

  assert_gap_hs_a_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_a) |-> !$past(ls_a));

  assert_gap_ls_b_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_b) |-> !$past(hs_b));

  assert_gap_hs_b_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_b) |-> !$past(ls_b));

endmodule

bind chopper_ctrl chopper_ctrl_chk #(.CNT_W(CNT_W), .MIN_ON(MIN_ON)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .enable    (enable),
  .phase_on  (phase_on),
  .phase_dir (phase_dir),
  .hs_a      (hs_a),
  .ls_a      (ls_a),
  .hs_b      (hs_b),
  .ls_b      (ls_b)
);

// File: tb/chopper_ctrl_bench.sv
`timescale 1ns/1ps
module chopper_ctrl_bench;

  localparam int DEAD   = 4;
  localparam int BLANK  = 4;
  localparam int MIN_ON = 10;
  localparam int OFF_T  = 20;

  typedef struct packed {
    logic       slow;
    logic       dir;
    logic [7:0] p_at;    // on-cycle where the flag pulse starts
    logic [7:0] p_len;   // pulse length in cycles
    logic [7:0] on_len;  // expected on-time, 0 = no trip expected
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 8'd12, 8'd1,  8'd13},  // R5 fast
    '{1'b1, 1'b1, 8'd12, 8'd1,  8'd13},  // R5 slow
    '{1'b0, 1'b0, 8'd15, 8'd1,  8'd16},  // R5 fast dir 0
    '{1'b1, 1'b0, 8'd15, 8'd1,  8'd16},  // R5 slow dir 0
    '{1'b0, 1'b1, 8'd0,  8'd4,  8'd0},   // R3 blanked only
    '{1'b1, 1'b0, 8'd0,  8'd20, 8'd10},  // R4 held from start
    '{1'b0, 1'b1, 8'd5,  8'd1,  8'd10},  // R4 remembered pulse
    '{1'b1, 1'b1, 8'd3,  8'd1,  8'd0},   // R3 last blanked cycle
    '{1'b0, 1'b0, 8'd9,  8'd1,  8'd10},  // R4/R5 boundary
    '{1'b1, 1'b1, 8'd4,  8'd1,  8'd10}   // R3 first unblanked cycle
  };

  logic clk = 1'b0;
  logic rst, enable, phase_on, phase_dir, slow_decay, over_ref;
  logic hs_a, ls_a, hs_b, ls_b;
  int   checks = 0;
  int   fails  = 0;
  int   overlap = 0;

  always #2.5 clk = ~clk;

  chopper_ctrl #(.DEAD(DEAD), .BLANK(BLANK), .MIN_ON(MIN_ON), .OFF_T(OFF_T)) u_chopper_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .phase_on(phase_on), .phase_dir(phase_dir),
    .slow_decay(slow_decay), .over_ref(over_ref),
    .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b)
  );

  function automatic logic [3:0] pins();
    return {hs_a, ls_a, hs_b, ls_b};
  endfunction

  function automatic logic [3:0] on_pat(input logic d);
    return d ? 4'b1001 : 4'b0110;
  endfunction

  function automatic logic [3:0] doff_pat(input logic s, input logic d);
    return s ? (d ? 4'b1000 : 4'b0010) : 4'b0000;
  endfunction

  function automatic logic [3:0] rec_pat(input logic s, input logic d);
    return s ? 4'b1010 : (d ? 4'b0100 : 4'b0001);
  endfunction

  task automatic check(input logic [3:0] exp, input string req);
    checks++;
    if (pins() !== exp) begin
      fails++;
      $display("FAIL %s: gates actual %b expected %b at %0t", req, pins(), exp, $time);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // R11 invariant, watched every cycle
  always @(negedge clk) begin
    if (!rst && ((hs_a && ls_a) || (hs_b && ls_b))) overlap++;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  // Disable, re-enable and return at the negedge of on-cycle 0
  task automatic start_on(input logic d, input logic s);
    @(negedge clk);
    enable = 1'b0; over_ref = 1'b0; phase_dir = d; slow_decay = s;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    repeat (DEAD + 1) @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v);
    int total;
    int len;
    len = int'(v.on_len);
    @(negedge clk);
    enable = 1'b0; over_ref = 1'b0; slow_decay = v.slow; phase_dir = v.dir;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    total = (len != 0) ? (DEAD + len + OFF_T + DEAD + 3) : (DEAD + 40);
    for (int c = 0; c < total; c++) begin
      int oi;
      int k;
      @(negedge clk);
      oi = c - DEAD;
      over_ref = 1'b0;
      if (c < DEAD) begin
        check(4'b0000, "R2 dead gap before conduction");
      end else if (len == 0 || oi < len) begin
        check(on_pat(v.dir), (len == 0) ? "R3 on-time kept" : "R2/R4/R5 on-time");
        if (oi >= int'(v.p_at) && oi < int'(v.p_at) + int'(v.p_len)) over_ref = 1'b1;
      end else begin
        k = oi - len;
        if (k < DEAD)
          check(doff_pat(v.slow, v.dir), v.slow ? "R7 slow dead gap" : "R6 fast dead gap");
        else if (k < OFF_T)
          check(rec_pat(v.slow, v.dir), v.slow ? "R7 slow recirc" : "R6 fast recirc");
        else if (k < OFF_T + DEAD)
          check(doff_pat(v.slow, v.dir), "R8 dead gap after off-time");
        else
          check(on_pat(v.dir), "R8 conduction resumes");
      end
    end
    over_ref = 1'b0;
  endtask

  initial begin
    rst = 1'b1; enable = 1'b1; phase_on = 1'b1; phase_dir = 1'b1;
    slow_decay = 1'b0; over_ref = 1'b0;
    repeat (3) @(negedge clk);
    check(4'b0000, "R1 reset state");
    rst = 1'b0;

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R9: decay mode latched at trip, later change ignored
    start_on(1'b1, 1'b0);
    check(4'b1001, "R9 setup on");
    repeat (10) @(negedge clk);
    over_ref = 1'b1;
    @(negedge clk);
    over_ref = 1'b0;
    check(4'b0000, "R9 fast dead gap");
    slow_decay = 1'b1;
    repeat (DEAD) @(negedge clk);
    check(4'b0100, "R9 recirc stays fast");
    repeat (OFF_T - DEAD) @(negedge clk);
    check(4'b0000, "R9 dead gap stays fast");
    repeat (DEAD) @(negedge clk);
    check(4'b1001, "R9 on again");
    over_ref = 1'b1;
    repeat (MIN_ON) @(negedge clk);
    over_ref = 1'b0;
    check(4'b1000, "R9 next off-time uses slow");

    // R10: polarity change during on-time
    start_on(1'b1, 1'b1);
    check(4'b1001, "R10 setup on");
    repeat (3) @(negedge clk);
    phase_dir = 1'b0;
    @(negedge clk);
    check(4'b0000, "R10 gates off after polarity change");
    repeat (DEAD - 1) @(negedge clk);
    check(4'b0000, "R10 still in dead gap");
    @(negedge clk);
    check(4'b0110, "R10 new polarity conducts");

    // R1: global disable and phase-enable low
    enable = 1'b0;
    @(negedge clk);
    check(4'b0000, "R1 enable low forces off");
    enable = 1'b1;
    repeat (DEAD + 1) @(negedge clk);
    check(4'b0110, "R2 conducting after re-enable");
    phase_on = 1'b0;
    @(negedge clk);
    check(4'b0000, "R1 phase_on low forces off");
    phase_on = 1'b1;
    repeat (3) @(negedge clk);

    checks++;
    if (overlap != 0) begin
      fails++;
      $display("FAIL R11: overlap cycles actual %0d expected 0", overlap);
    end
    summary();
  end

endmodule